// File: doc/BRIEF.md
# Parallel Flash Programming Controller

This block is the parallel programming front end of a small on-chip code flash. An external programmer puts an address, a data byte and a three-bit mode code on the inputs. It holds a program-enable level and pulses an active-low program strobe. Byte programming and lock-bit programming time themselves: the rising edge of the strobe starts a write, and the write finishes on an internal count of `WRITE_CLKS` clocks. While the write runs, the `ready` output is low. A verify read of the address being written returns the data with bit 7 inverted, which lets the programmer poll for completion.

A chip erase happens only when the strobe is held low in erase mode for `ERASE_CLKS` clocks in a row. It sets every byte to FFh and clears both lock bits. A byte can be programmed only while it is blank (FFh). Once either lock bit is set, verify reads stop showing the array contents. Signature reads return a fixed three-byte identity. The array is a register array that needs no reset and starts out erased. Reset affects only the controller.

The sequencer has four states:

| State | Behaviour | Ready |
|-------|-----------|-------|
| IDLE | Waits for a command. | high |
| PROG | Counts down the self-timed write. | low |
| ERASE | Lasts one cycle and clears the whole array. | high |
| RELEASE | Waits for the strobe to return high after an erase. | high |

The transitions are:
- IDLE→PROG: a strobe rising edge in a write or lock mode with the enable high.
- PROG→IDLE: the write count expires and the write commits.
- IDLE→ERASE: the strobe has been held low for the full erase time.
- ERASE→RELEASE: always, after one cycle.
- RELEASE→IDLE: the strobe is high.

Top module: `flash_prog_ctrl`

## Requirements
- R1: After reset `ready` is high. A verify read (mode 010) of any address in the untouched array returns FFh.
- R2: A write command starts when the enable is high and the strobe rises, sampled as low then high on two clock edges, with mode 001 present. `ready` falls on the next cycle and stays low for exactly `WRITE_CLKS` cycles. The byte is then stored.
- R3: While a byte write is in progress, a verify read of the target address returns the written byte with bit 7 inverted. A verify read of any other address returns FFh. Any mode other than verify or signature drives FFh.
- R4: A byte write to a location that does not hold FFh leaves that location unchanged.
- R5: A write, lock or erase command issued while `ready` is low is ignored.
- R6: In mode 011, holding the strobe low for `ERASE_CLKS` consecutive sampled clocks sets every byte to FFh and clears both lock bits. Any shorter hold changes nothing.
- R7: A signature read (mode 110) returns 1Eh at offset 30h and 51h at offset 31h. At offset 32h it returns FFh when `HV_VARIANT`=1 and 05h when it is 0. Every other offset returns FFh.
- R8: Lock bits are programmed with modes 100 and 101, using the same self-timed sequence as a byte write. While either lock bit is set, every verify read returns FFh.
- R9: Write, lock and erase commands have no effect while the enable input is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low reset for the controller; does not affect the array |
| addr | input | ADDR_W | Byte address, or signature offset |
| din | input | 8 | Byte to program |
| mode | input | 3 | Operation select code |
| prog_n | input | 1 | Active-low program strobe |
| pen | input | 1 | Program-enable level |
| dout | output | 8 | Read data, polling status, or signature byte |
| ready | output | 1 | High when no self-timed write is running |

## Verification
The embedded assertions check the following on every cycle:
- the sequencer stays idle while the enable is low;
- the write counter stays bounded;
- the captured address and data are frozen while busy;
- an erase is reached only through a held-low strobe;
- a non-blank byte survives a commit;
- an erase clears both the array edges and the lock bits;
- locked and busy verify reads return FFh.

Only the bench scenarios can show the exact cycle at which `ready` falls and rises, and the polled value with bit 7 inverted. The same holds for the effect of a short versus a full erase hold, the rejection of a command sent while busy, the signature bytes, and the end-to-end effect of a lock bit on read-back.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
    typedef enum logic [2:0] {
        M_NOP    = 3'd0,
        M_WRITE  = 3'd1,
        M_VERIFY = 3'd2,
        M_ERASE  = 3'd3,
        M_LOCK1  = 3'd4,
        M_LOCK2  = 3'd5,
        M_SIG    = 3'd6
    } fpc_mode_e;

    typedef enum logic [1:0] {
        S_IDLE, S_PROG, S_ERASE, S_RELEASE
    } fpc_state_e;

    typedef enum logic [1:0] {
        T_BYTE, T_LOCK1, T_LOCK2
    } fpc_target_e;
endpackage

// File: rtl/fpc_sequencer.sv
module fpc_sequencer
    import fpc_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int WRITE_CLKS = 75000,
    parameter int ERASE_CLKS = 500000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        mode,
    input  logic              prog_n,
    input  logic              pen,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic              busy,
    output logic              tgt_byte,
    output logic [ADDR_W-1:0] waddr,
    output logic [7:0]        wdata,
    output logic              commit_byte,
    output logic              commit_lock1,
    output logic              commit_lock2,
    output logic              erase_pulse
);
    localparam int WCW = $clog2(WRITE_CLKS + 1);
    localparam int ECW = $clog2(ERASE_CLKS + 1);

    fpc_state_e  state, state_nx;
    fpc_target_e tgt_q;
    logic [WCW-1:0] wcnt;
    logic [ECW-1:0] ecnt;
    logic        prog_q;
    logic        wr_mode, start, hold_ok, erase_go, wr_done;

    assign wr_mode  = (mode == M_WRITE) || (mode == M_LOCK1) || (mode == M_LOCK2);
    assign start    = (state == S_IDLE) && pen && prog_n && !prog_q && wr_mode;
    assign hold_ok  = (state == S_IDLE) && pen && !prog_n && (mode == M_ERASE);
    assign erase_go = hold_ok && (ecnt == ECW'(ERASE_CLKS - 1));
    assign wr_done  = (state == S_PROG) && (wcnt == '0);

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:    if (start) state_nx = S_PROG;
                       else if (erase_go) state_nx = S_ERASE;
            S_PROG:    if (wr_done) state_nx = S_IDLE;
            S_ERASE:   state_nx = S_RELEASE;
            S_RELEASE: if (prog_n) state_nx = S_IDLE;
            default:   state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            prog_q <= 1'b1;
            wcnt   <= '0;
            ecnt   <= '0;
            tgt_q  <= T_BYTE;
            waddr  <= '0;
            wdata  <= 8'hFF;
        end else begin
            state  <= state_nx;
            prog_q <= prog_n;
            ecnt   <= (hold_ok && !erase_go) ? ecnt + 1'b1 : '0;
            if (start) begin
                wcnt  <= WCW'(WRITE_CLKS - 1);
                waddr <= addr;
                wdata <= din;
                unique case (mode)
                    M_LOCK1: tgt_q <= T_LOCK1;
                    M_LOCK2: tgt_q <= T_LOCK2;
                    default: tgt_q <= T_BYTE;
                endcase
            end else if (state == S_PROG && !wr_done) begin
                wcnt <= wcnt - 1'b1;
            end
        end
    end

    always_comb begin
        busy         = (state == S_PROG);
        tgt_byte     = (tgt_q == T_BYTE);
        commit_byte  = wr_done && (tgt_q == T_BYTE);
        commit_lock1 = wr_done && (tgt_q == T_LOCK1);
        commit_lock2 = wr_done && (tgt_q == T_LOCK2);
        erase_pulse  = (state == S_ERASE);
    end

    // R9
    idle_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && !pen) |=> (state == S_IDLE));
    // R2
    write_count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PROG) |-> (wcnt < WCW'(WRITE_CLKS)));
    // R5
    busy_freezes_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PROG && wcnt != '0) |=> (state == S_PROG && $stable(waddr) && $stable(wdata)));
    // R6
    erase_needs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ERASE) |-> (!$past(prog_n) && $past(mode) == M_ERASE));
endmodule

// File: rtl/fpc_array.sv
module fpc_array
    import fpc_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter bit HV_VARIANT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        mode,
    input  logic [ADDR_W-1:0] raddr,
    input  logic              busy,
    input  logic              tgt_byte,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic              commit_byte,
    input  logic              commit_lock1,
    input  logic              commit_lock2,
    input  logic              erase_pulse,
    output logic [7:0]        dout
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [7:0] SIG_LAST = HV_VARIANT ? 8'hFF : 8'h05;

    logic [7:0] mem [DEPTH] = '{default: 8'hFF};
    logic       lock1 = 1'b0;
    logic       lock2 = 1'b0;

    always_ff @(posedge clk) begin
        if (erase_pulse) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
            lock1 <= 1'b0;
            lock2 <= 1'b0;
        end else begin
            if (commit_byte && mem[waddr] == 8'hFF) mem[waddr] <= wdata;
            if (commit_lock1) lock1 <= 1'b1;
            if (commit_lock2) lock2 <= 1'b1;
        end
    end

    always_comb begin
        dout = 8'hFF;
        if (mode == M_VERIFY) begin
            if (lock1 || lock2)               dout = 8'hFF;
            else if (busy)                    dout = (tgt_byte && raddr == waddr) ?
                                                     {~wdata[7], wdata[6:0]} : 8'hFF;
            else                              dout = mem[raddr];
        end else if (mode == M_SIG) begin
            if (raddr == ADDR_W'(8'h30))      dout = 8'h1E;
            else if (raddr == ADDR_W'(8'h31)) dout = 8'h51;
            else if (raddr == ADDR_W'(8'h32)) dout = SIG_LAST;
        end
    end

    // R4
    nonblank_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_byte && mem[waddr] != 8'hFF) |=> (mem[waddr] == $past(mem[waddr])));
    // R6
    erase_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        erase_pulse |=> (!lock1 && !lock2 && mem[0] == 8'hFF && mem[DEPTH-1] == 8'hFF));
    // R8
    locked_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_VERIFY && (lock1 || lock2)) |-> (dout == 8'hFF));
    // R3
    busy_other_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mode == M_VERIFY && raddr != waddr) |-> (dout == 8'hFF));
endmodule

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl #(
    parameter int ADDR_W     = 8,
    parameter int WRITE_CLKS = 75000,
    parameter int ERASE_CLKS = 500000,
    parameter bit HV_VARIANT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    input  logic [2:0]        mode,
    input  logic              prog_n,
    input  logic              pen,
    output logic [7:0]        dout,
    output logic              ready
);
    logic              busy, tgt_byte, commit_byte, commit_lock1, commit_lock2, erase_pulse;
    logic [ADDR_W-1:0] waddr;
    logic [7:0]        wdata;

    fpc_sequencer #(.ADDR_W(ADDR_W), .WRITE_CLKS(WRITE_CLKS), .ERASE_CLKS(ERASE_CLKS)) u_seq (
        .clk(clk), .rst_n(rst_n), .mode(mode), .prog_n(prog_n), .pen(pen),
        .addr(addr), .din(din), .busy(busy), .tgt_byte(tgt_byte),
        .waddr(waddr), .wdata(wdata), .commit_byte(commit_byte),
        .commit_lock1(commit_lock1), .commit_lock2(commit_lock2),
        .erase_pulse(erase_pulse)
    );

    fpc_array #(.ADDR_W(ADDR_W), .HV_VARIANT(HV_VARIANT)) u_arr (
        .clk(clk), .rst_n(rst_n), .mode(mode), .raddr(addr), .busy(busy),
        .tgt_byte(tgt_byte), .waddr(waddr), .wdata(wdata),
        .commit_byte(commit_byte), .commit_lock1(commit_lock1),
        .commit_lock2(commit_lock2), .erase_pulse(erase_pulse), .dout(dout)
    );

    assign ready = !busy;
endmodule

// File: tb/flash_prog_ctrl_bench.sv
module flash_prog_ctrl_bench;
    localparam int AW = 8;
    localparam int WC = 8;
    localparam int EC = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    din = 8'h00;
    logic [2:0]    mode = 3'd0;
    logic          prog_n = 1'b1;
    logic          pen = 1'b0;
    logic [7:0]    dout;
    logic          ready;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    flash_prog_ctrl #(.ADDR_W(AW), .WRITE_CLKS(WC), .ERASE_CLKS(EC), .HV_VARIANT(1'b1)) u_flash_prog_ctrl (
        .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .mode(mode),
        .prog_n(prog_n), .pen(pen), .dout(dout), .ready(ready)
    );

    // behavioural reference model
    logic [7:0] mm [256];
    int         ms = 0, mcnt = 0, mlow = 0;
    logic       mprev = 1'b1, ml1 = 1'b0, ml2 = 1'b0;
    logic [AW-1:0] mla = '0;
    logic [7:0] mld = 8'hFF;
    logic [2:0] mtg = 3'd1;

    initial for (int i = 0; i < 256; i++) mm[i] = 8'hFF;

    always @(posedge clk) begin
        if (!rst_n) begin
            ms = 0; mcnt = 0; mlow = 0; mprev = 1'b1;
        end else begin
            case (ms)
                0: begin
                    if (pen && prog_n && !mprev && (mode == 3'd1 || mode == 3'd4 || mode == 3'd5)) begin
                        ms = 1; mcnt = 0; mla = addr; mld = din; mtg = mode; mlow = 0;
                    end else if (pen && !prog_n && mode == 3'd3) begin
                        mlow++;
                        if (mlow == EC) begin ms = 2; mlow = 0; end
                    end else mlow = 0;
                end
                1: begin
                    mcnt++;
                    if (mcnt == WC) begin
                        if (mtg == 3'd1 && mm[mla] == 8'hFF) mm[mla] = mld;
                        if (mtg == 3'd4) ml1 = 1'b1;
                        if (mtg == 3'd5) ml2 = 1'b1;
                        ms = 0;
                    end
                end
                2: begin
                    for (int i = 0; i < 256; i++) mm[i] = 8'hFF;
                    ml1 = 1'b0; ml2 = 1'b0; ms = 3;
                end
                default: if (prog_n) ms = 0;
            endcase
            mprev = prog_n;
        end
    end

    function automatic logic [7:0] exp_dout();
        if (mode == 3'd2) begin
            if (ml1 || ml2) return 8'hFF;
            if (ms == 1) return (mtg == 3'd1 && addr == mla) ? {~mld[7], mld[6:0]} : 8'hFF;
            return mm[addr];
        end
        if (mode == 3'd6) begin
            if (addr == 8'h30) return 8'h1E;
            if (addr == 8'h31) return 8'h51;
            if (addr == 8'h32) return 8'hFF;
        end
        return 8'hFF;
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(posedge clk) begin
        #2;
        if (rst_n && !done) begin
            chk({cur_req, " dout"}, dout, exp_dout());
            chk({cur_req, " ready"}, {7'd0, ready}, {7'd0, (ms != 1)});
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(logic [2:0] m, logic [AW-1:0] a, logic [7:0] d);
        @(negedge clk); mode = m; addr = a; din = d; prog_n = 1'b0;
        @(negedge clk); prog_n = 1'b1;
    endtask

    task automatic read(logic [2:0] m, logic [AW-1:0] a);
        @(negedge clk); mode = m; addr = a;
        #1;
    endtask

    task automatic hold_erase(int n);
        @(negedge clk); mode = 3'd3; prog_n = 1'b0;
        repeat (n) @(negedge clk);
        prog_n = 1'b1;
        cyc(2);
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        pen = 1'b1;
        #1;
        cur_req = "R1";
        chk("R1 ready after reset", {7'd0, ready}, 8'h01);
        read(3'd2, 8'h05);
        chk("R1 blank array", dout, 8'hFF);

        cur_req = "R2";
        pulse(3'd1, 8'h10, 8'hA5);
        read(3'd2, 8'h10);
        chk("R2 ready low while writing", {7'd0, ready}, 8'h00);
        chk("R3 polled bit7 inverted", dout, 8'h25);
        read(3'd2, 8'h11);
        chk("R3 other address while busy", dout, 8'hFF);
        read(3'd0, 8'h10);
        chk("R3 non-read mode drives ones", dout, 8'hFF);
        cyc(WC);
        read(3'd2, 8'h10);
        chk("R2 stored byte", dout, 8'hA5);
        chk("R2 ready back high", {7'd0, ready}, 8'h01);

        cur_req = "R4";
        pulse(3'd1, 8'h10, 8'h00);
        cyc(WC + 2);
        read(3'd2, 8'h10);
        chk("R4 nonblank unchanged", dout, 8'hA5);

        cur_req = "R5";
        pulse(3'd1, 8'h20, 8'h3C);
        pulse(3'd1, 8'h21, 8'h77);
        pulse(3'd4, 8'h00, 8'h00);
        cyc(WC + 2);
        read(3'd2, 8'h21);
        chk("R5 busy write ignored", dout, 8'hFF);
        read(3'd2, 8'h20);
        chk("R5 first write kept, busy lock ignored", dout, 8'h3C);

        cur_req = "R9";
        pen = 1'b0;
        pulse(3'd1, 8'h30, 8'h11);
        read(3'd2, 8'h30);
        chk("R9 ready stays high", {7'd0, ready}, 8'h01);
        hold_erase(EC + 3);
        read(3'd2, 8'h30);
        chk("R9 write ignored", dout, 8'hFF);
        read(3'd2, 8'h10);
        chk("R9 erase ignored", dout, 8'hA5);
        pen = 1'b1;

        cur_req = "R7";
        read(3'd6, 8'h30); chk("R7 sig 30", dout, 8'h1E);
        read(3'd6, 8'h31); chk("R7 sig 31", dout, 8'h51);
        read(3'd6, 8'h32); chk("R7 sig 32", dout, 8'hFF);
        read(3'd6, 8'h33); chk("R7 sig other", dout, 8'hFF);

        cur_req = "R6";
        hold_erase(EC - 1);
        read(3'd2, 8'h10);
        chk("R6 short hold no erase", dout, 8'hA5);

        cur_req = "R8";
        pulse(3'd4, 8'h00, 8'h00);
        read(3'd2, 8'h10);
        chk("R8 lock write busy", {7'd0, ready}, 8'h00);
        cyc(WC + 2);
        read(3'd2, 8'h10);
        chk("R8 locked verify hidden", dout, 8'hFF);
        read(3'd6, 8'h30);
        chk("R8 signature still readable", dout, 8'h1E);

        cur_req = "R6";
        hold_erase(EC + 3);
        read(3'd2, 8'h20);
        chk("R6 full erase clears array", dout, 8'hFF);
        pulse(3'd1, 8'h10, 8'h5A);
        cyc(WC + 2);
        read(3'd2, 8'h10);
        chk("R6 lock cleared by erase", dout, 8'h5A);

        cur_req = "R8";
        pulse(3'd5, 8'h00, 8'h00);
        cyc(WC + 2);
        read(3'd2, 8'h10);
        chk("R8 second lock hides", dout, 8'hFF);

        cyc(2);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule